// File: doc/BRIEF.md
# Adjustable-Rate System Time Counter

This block keeps a free-running 64-bit time value for stamping packets. The value counts in fine fractional units. With a 16 ns counter clock and an increment of 16 × 2^19 (0x800000), one unit is 2^-19 ns, so a right shift by 19 gives nanoseconds. Software corrects the rate by a few ppm. It does this by moving the per-tick increment a little above or below its nominal value. The 24-bit increment field leaves room for the nominal value plus that correction.

Software reaches the block through a small 32-bit register port with three registers. Two registers hold the low and high halves of the time value. The third is a rate register, which packs the per-tick increment and a tick period counted in clock cycles. All three can be read and written. A 64-bit read is made as a low-word read followed by a high-word read. The low-word read saves the matching high half, so the two halves always belong to the same instant, even when a carry falls between the two reads. The count wraps modulo 2^64.

Top module: `systime_counter`

## Requirements
- R1: After reset the low word, high word and rate register all read 0. With an increment field of 0 the time value stays still.
- R2: The rate register at select 2 holds the increment in bits [23:0] and the tick period in clock cycles in bits [31:24]. With period 1, the increment is added on every clock cycle.
- R3: A period field of 0 behaves exactly like a period of 1.
- R4: Writing the rate register restarts the period divider, and nothing is added in the write cycle. With period P, the first addition happens P cycles after the write edge, and further additions follow every P cycles.
- R5: A write to select 0 replaces the low word and keeps the high word. A write to select 1 replaces the high word and keeps the low word. The new value is visible from the next cycle, and the increment due in the write cycle is dropped.
- R6: The time value is a 64-bit count. A carry out of the low word goes into the high word, and all ones plus the increment wraps through zero.
- R7: A read of select 0 returns the low word and saves the high word of the same instant in a shadow. A read of select 1 returns that shadow and not the live high word.
- R8: Read data is registered. It shows up the cycle after the read strobe and holds until the next read. A read of select 2 returns the rate register, and a read of select 3 returns 0.
- R9: A write to select 3 has no effect: the rate register, the time value and the running count are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe for the selected register |
| addr | input | 2 | Register select: 0 low time, 1 high time, 2 rate, 3 unused |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
The counting path is swept over every tick period from 0 to 4. Each period is combined with increments of 1, 0x123, the nominal 0x800000 and the maximum 0xFFFFFF, and sampled at two different idle lengths. The short idle length separates an off-by-one in the divider restart from a correct first tick. The long one exposes a wrong tick spacing. Loads next to 0xFFFFFFFF in the low and high words, with large increments, separate a correct carry and wrap from a truncated count. A low read taken just before a carry, followed by a high read taken after it, separates the shadowed high read from a live one.

// File: rtl/systime_pkg.sv
package systime_pkg;
   typedef enum logic [1:0] {
      SEL_TLO  = 2'd0,
      SEL_THI  = 2'd1,
      SEL_RATE = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
   parameter int PER_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [PER_W-1:0] period,
   output logic             tick
);
   logic [PER_W-1:0] cnt_q;
   logic [PER_W-1:0] last_cnt;

   // a zero period is taken as one cycle per tick
   assign last_cnt = (period == '0) ? '0 : period - 1'b1;
   assign tick     = !restart && (cnt_q >= last_cnt);

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (tick)    cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/time_accum.sv
module time_accum #(
   parameter int TIME_W = 64,
   parameter int WORD_W = 32,
   parameter int INC_W  = 24
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tick,
   input  logic [INC_W-1:0]           inc,
   input  logic [TIME_W/WORD_W-1:0]   wr_word,
   input  logic [WORD_W-1:0]          wdata,
   output logic [TIME_W-1:0]          time_q
);
   localparam int NWORDS = TIME_W / WORD_W;

   logic [TIME_W-1:0] sum;
   logic [TIME_W-1:0] time_d;
   logic              hold;

   assign sum  = time_q + (tick ? {{(TIME_W-INC_W){1'b0}}, inc} : '0);
   assign hold = |wr_word;

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      always_comb begin
         if (wr_word[w])
            time_d[w*WORD_W +: WORD_W] = wdata;
         else if (hold)
            time_d[w*WORD_W +: WORD_W] = time_q[w*WORD_W +: WORD_W];
         else
            time_d[w*WORD_W +: WORD_W] = sum[w*WORD_W +: WORD_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) time_q <= '0;
      else        time_q <= time_d;
   end
endmodule

// File: rtl/reg_port.sv
module reg_port
   import systime_pkg::*;
#(
   parameter int TIME_W = 64,
   parameter int WORD_W = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic                      rd_en,
   input  logic [1:0]                addr,
   input  logic [WORD_W-1:0]         wdata,
   input  logic [TIME_W-1:0]         time_q,
   output logic [TIME_W/WORD_W-1:0]  wr_word,
   output logic                      rate_wr,
   output logic [WORD_W-1:0]         rate_q,
   output logic [WORD_W-1:0]         shadow_q,
   output logic [WORD_W-1:0]         rdata
);
   reg_sel_e          sel;
   logic [WORD_W-1:0] rdata_q;

   assign sel        = reg_sel_e'(addr);
   assign wr_word[0] = wr_en && (sel == SEL_TLO);
   assign wr_word[1] = wr_en && (sel == SEL_THI);
   assign rate_wr    = wr_en && (sel == SEL_RATE);
   assign rdata      = rdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       rate_q <= '0;
      else if (rate_wr) rate_q <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_q <= '0;
         rdata_q  <= '0;
      end else if (rd_en) begin
         unique case (sel)
            SEL_TLO: begin
               rdata_q  <= time_q[WORD_W-1:0];
               shadow_q <= time_q[TIME_W-1:WORD_W];
            end
            SEL_THI:  rdata_q <= shadow_q;
            SEL_RATE: rdata_q <= rate_q;
            default:  rdata_q <= '0;
         endcase
      end
   end
endmodule

// File: rtl/systime_counter.sv
module systime_counter #(
   parameter int TIME_W = 64,
   parameter int WORD_W = 32,
   parameter int INC_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata
);
   localparam int PER_W  = WORD_W - INC_W;
   localparam int NWORDS = TIME_W / WORD_W;

   if (TIME_W != 2 * WORD_W) begin : g_bad_time_w
      $error("TIME_W must be exactly two register words");
   end
   if (INC_W < 1 || INC_W >= WORD_W) begin : g_bad_inc_w
      $error("INC_W must leave room for a period field");
   end

   logic [TIME_W-1:0] time_q;
   logic [WORD_W-1:0] rate_q;
   logic [WORD_W-1:0] shadow_q;
   logic [NWORDS-1:0] wr_word;
   logic              rate_wr;
   logic              tick;

   reg_port #(.TIME_W(TIME_W), .WORD_W(WORD_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .time_q(time_q),
      .wr_word(wr_word), .rate_wr(rate_wr), .rate_q(rate_q),
      .shadow_q(shadow_q), .rdata(rdata)
   );

   tick_divider #(.PER_W(PER_W)) u_div (
      .clk(clk), .rst_n(rst_n), .restart(rate_wr),
      .period(rate_q[WORD_W-1:INC_W]), .tick(tick)
   );

   time_accum #(.TIME_W(TIME_W), .WORD_W(WORD_W), .INC_W(INC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .inc(rate_q[INC_W-1:0]), .wr_word(wr_word), .wdata(wdata),
      .time_q(time_q)
   );
endmodule

// File: rtl/systime_counter_chk.sv
module systime_counter_chk #(
   parameter int TIME_W = 64,
   parameter int WORD_W = 32,
   parameter int INC_W  = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [1:0]        addr,
   input logic [WORD_W-1:0] wdata,
   input logic [WORD_W-1:0] rdata,
   input logic [TIME_W-1:0] time_q,
   input logic [WORD_W-1:0] rate_q,
   input logic [WORD_W-1:0] shadow_q
);
   // R1
   zero_inc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_q[INC_W-1:0] == '0 && !wr_en) |=> $stable(time_q));

   // R2
   every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && rate_q[WORD_W-1:INC_W] == 1)
      |=> time_q == $past(time_q) + {{(TIME_W-INC_W){1'b0}}, $past(rate_q[INC_W-1:0])});

   // R5
   lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd0)
      |=> (time_q[WORD_W-1:0] == $past(wdata)) &&
          (time_q[TIME_W-1:WORD_W] == $past(time_q[TIME_W-1:WORD_W])));

   // R5
   hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd1)
      |=> (time_q[TIME_W-1:WORD_W] == $past(wdata)) &&
          (time_q[WORD_W-1:0] == $past(time_q[WORD_W-1:0])));

   // R7
   lo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == 2'd0)
      |=> (rdata == $past(time_q[WORD_W-1:0])) &&
          (shadow_q == $past(time_q[TIME_W-1:WORD_W])));

   // R7
   hi_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == 2'd1) |=> rdata == $past(shadow_q));

   // R8
   rate_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == 2'd2) |=> rdata == $past(rate_q));

   // R8
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

   // R9
   unused_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd3) |=> $stable(rate_q));
endmodule

bind systime_counter systime_counter_chk #(
   .TIME_W(TIME_W), .WORD_W(WORD_W), .INC_W(INC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wdata(wdata), .rdata(rdata), .time_q(time_q), .rate_q(rate_q),
   .shadow_q(shadow_q)
);

// File: tb/systime_counter_bench.sv
`timescale 1ns/1ps
module systime_counter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // requirement-level reference state
   logic [63:0] m_time;
   logic [31:0] m_rate, m_shadow, m_rdata;
   logic [7:0]  m_cnt;

   always #5 clk = ~clk;

   systime_counter u_systime_counter (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_time = '0; m_rate = '0; m_shadow = '0; m_rdata = '0; m_cnt = '0;
      end else begin
         logic [7:0] per, last;
         logic       rw, tk;
         per  = m_rate[31:24];
         last = (per == 0) ? 8'd0 : per - 8'd1;
         rw   = wr_en && addr == 2'd2;
         tk   = !rw && (m_cnt >= last);
         if (rd_en) begin
            case (addr)
               2'd0: begin m_rdata = m_time[31:0]; m_shadow = m_time[63:32]; end
               2'd1: m_rdata = m_shadow;
               2'd2: m_rdata = m_rate;
               default: m_rdata = '0;
            endcase
         end
         if (wr_en && addr == 2'd0)      m_time[31:0]  = wdata;
         else if (wr_en && addr == 2'd1) m_time[63:32] = wdata;
         else if (tk)                    m_time = m_time + {40'd0, m_rate[23:0]};
         if (rw || tk) m_cnt = '0;
         else          m_cnt = m_cnt + 8'd1;
         if (rw) m_rate = wdata;
      end
   end

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [1:0] a);
      @(negedge clk); rd_en = 1'b1; addr = a;
      @(negedge clk); rd_en = 1'b0;
      check(req, rdata, m_rdata);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      logic [31:0] incs [4];
      incs[0] = 32'h1; incs[1] = 32'h123; incs[2] = 32'h800000; incs[3] = 32'hFFFFFF;
      idle(3);
      rst_n = 1'b1;
      // R1: reset state and stopped counter
      rd_check("R1 low", 2'd0);
      check("R1 low zero", rdata, 32'h0);
      rd_check("R1 high", 2'd1);
      rd_check("R1 rate", 2'd2);
      check("R1 rate zero", rdata, 32'h0);
      idle(10);
      rd_check("R1 still", 2'd0);
      check("R1 still zero", rdata, 32'h0);

      // R2 R3 R4: period and increment sweep
      for (int p = 0; p <= 4; p++) begin
         for (int k = 0; k < 4; k++) begin
            for (int w = 0; w < 2; w++) begin
               wr(2'd0, 32'h0);
               wr(2'd1, 32'h0);
               wr(2'd2, {p[7:0], incs[k][23:0]});
               idle(w == 0 ? 1 : 9);
               rd_check(p == 0 ? "R3 sweep low" : (p == 1 ? "R2 sweep low" : "R4 sweep low"), 2'd0);
               rd_check("R4 sweep high", 2'd1);
            end
         end
      end
      // R4 explicit arithmetic: period 3, increment 5, read 7 cycles after write edge
      wr(2'd2, 32'h0);
      wr(2'd0, 32'h0);
      wr(2'd1, 32'h0);
      @(negedge clk); wr_en = 1'b1; addr = 2'd2; wdata = {8'd3, 24'd5};
      @(negedge clk); wr_en = 1'b0;
      idle(5);
      @(negedge clk); rd_en = 1'b1; addr = 2'd0;
      @(negedge clk); rd_en = 1'b0;
      // read samples after edge 7 past the write: additions at +3 and +6
      check("R4 explicit", rdata, 32'd10);
      rd_check("R2 rate readback", 2'd2);
      check("R2 rate value", rdata, {8'd3, 24'd5});

      // R5: half writes while running
      wr(2'd2, {8'd1, 24'h800000});
      wr(2'd1, 32'hA5A5_0001);
      wr(2'd0, 32'h0000_1000);
      rd_check("R5 low", 2'd0);
      rd_check("R5 high", 2'd1);
      check("R5 high kept", rdata, 32'hA5A5_0001);
      wr(2'd1, 32'h1234_5678);
      rd_check("R5 low kept", 2'd0);
      rd_check("R5 high new", 2'd1);

      // R6: carry into high word and full wrap
      wr(2'd2, 32'h0);
      wr(2'd1, 32'h0000_0005);
      wr(2'd0, 32'hFFF0_0000);
      wr(2'd2, {8'd1, 24'h800000});
      idle(4);
      rd_check("R6 carry low", 2'd0);
      rd_check("R6 carry high", 2'd1);
      check("R6 carry high val", rdata, 32'h0000_0006);
      wr(2'd2, 32'h0);
      wr(2'd1, 32'hFFFF_FFFF);
      wr(2'd0, 32'hFF00_0000);
      wr(2'd2, {8'd1, 24'h800000});
      idle(4);
      rd_check("R6 wrap low", 2'd0);
      rd_check("R6 wrap high", 2'd1);
      check("R6 wrap high val", rdata, 32'h0);
      wr(2'd1, 32'hFF80_0000);
      rd_check("R6 load low", 2'd0);
      rd_check("R6 load high", 2'd1);
      check("R6 load high val", rdata, 32'hFF80_0000);

      // R7: shadowed high read across a carry
      wr(2'd2, 32'h0);
      wr(2'd1, 32'h0000_0007);
      wr(2'd0, 32'hFF00_0000);
      wr(2'd2, {8'd1, 24'h800000});
      rd_check("R7 low", 2'd0);
      idle(6);
      rd_check("R7 high shadow", 2'd1);
      check("R7 shadow val", rdata, 32'h0000_0007);
      rd_check("R7 low again", 2'd0);
      rd_check("R7 high new", 2'd1);
      check("R7 new val", rdata, 32'h0000_0008);

      // R8: select 3 reads zero, data holds between reads
      rd_check("R8 sel3", 2'd3);
      check("R8 sel3 zero", rdata, 32'h0);
      rd_check("R8 rate", 2'd2);
      idle(3);
      check("R8 hold", rdata, {8'd1, 24'h800000});

      // R9: write to select 3 ignored
      wr(2'd3, 32'hDEAD_BEEF);
      rd_check("R9 rate", 2'd2);
      check("R9 rate val", rdata, {8'd1, 24'h800000});
      rd_check("R9 time low", 2'd0);
      rd_check("R9 time high", 2'd1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 100000; i++) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule